// File: doc/BRIEF.md
# Interrupt Destination Match and Fan-out

This block turns one interrupt message into a per-agent delivery mask over a set of up to 32 local interrupt agents. A message carries a 32-bit destination, a physical/logical flag, a 3-bit delivery code, a 2-bit shorthand, INIT level and trigger bits, an 8-bit vector and the index of the sending agent. Each agent describes itself through a presence bit, an extended-mode flag, a flat/cluster model bit, an 8-bit legacy ID, a 32-bit extended ID, an 8-bit legacy logical destination and a 32-bit extended logical destination.

Every agent has its own matcher. Legacy agents use 8-bit physical IDs and flat or cluster logical addressing. Extended agents use 32-bit physical IDs and a 16-bit-cluster / 16-bit-member logical scheme. Each mode has its own broadcast rule. A shorthand can override the destination with self, all, or all-but-self. The result is registered one cycle after the message, together with a delivery kind and the vector. The receiving interrupt controllers act on the mask.

Top module: `irq_dest_fanout`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a clock edge at which `msg_valid` was high. `out_mask`, `out_kind` and `out_vector` change only on such edges and hold otherwise. After reset all outputs are zero.
- R2: In physical mode with shorthand 0, a legacy agent (`agt_x2`=0) matches when destination bits [7:0] equal its 8-bit ID, whatever the upper 24 bits are. An extended agent matches when all 32 bits equal its extended ID.
- R3: A physical destination of 0xFFFFFFFF selects every present agent. A physical destination of exactly 0x000000FF selects every present legacy agent, in addition to the ID matches.
- R4: In logical mode, a legacy agent with model bit 0 (flat) matches when destination bits [7:0] ANDed with its logical destination are non-zero.
- R5: In logical mode, a legacy agent with model bit 1 (cluster) matches when destination bits [7:4] equal its logical bits [7:4] or equal 0xF, and destination bits [3:0] overlap its logical bits [3:0].
- R6: In logical mode, an extended agent matches when destination bits [31:16] equal its extended logical bits [31:16] and bits [15:0] overlap. A logical destination of 0xFFFFFFFF selects every present extended agent, and legacy agents still apply R4/R5 to bits [7:0].
- R7: Shorthand 1 selects only the sender (`msg_sender` index). Shorthand 2 selects all present agents. Shorthand 3 selects all present agents except the sender. In all three cases the destination fields are ignored.
- R8: Delivery code 001 (lowest priority) sets only the lowest-indexed selected agent. If no agent is selected, the mask is empty.
- R9: `out_kind` encodes 0 none, 1 vector, 2 SMI, 3 NMI, 4 INIT, 5 arbitration-ID reload. Delivery codes map as follows: 000 and 001 give kind 1; 010 gives 2; 100 gives 3; 101 gives 4, or 5 when `msg_level`=0 and `msg_trig`=1. Codes 011, 110 and 111 give kind 0 with an empty mask. `out_vector` carries `msg_vector` for kind 1 and is 0 otherwise.
- R10: An agent whose `agt_present` bit is 0 is never set in `out_mask`, under any mode or shorthand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | Message present this cycle |
| msg_dest | input | 32 | Destination field |
| msg_logical | input | 1 | 1 = logical destination, 0 = physical |
| msg_dlv | input | 3 | Delivery code |
| msg_level | input | 1 | INIT level bit |
| msg_trig | input | 1 | INIT trigger bit |
| msg_short | input | 2 | Shorthand: 0 none, 1 self, 2 all, 3 all-but-self |
| msg_vector | input | 8 | Interrupt vector |
| msg_sender | input | 5 | Index of the sending agent |
| agt_present | input | 32 | Agent exists and is enabled |
| agt_x2 | input | 32 | Agent is in extended mode |
| agt_cluster | input | 32 | Legacy logical model: 1 cluster, 0 flat |
| agt_id | input | 256 | 8-bit legacy IDs, agent i at [8i+7:8i] |
| agt_xid | input | 1024 | 32-bit extended IDs, agent i at [32i+31:32i] |
| agt_ldest | input | 256 | 8-bit legacy logical destinations |
| agt_xldest | input | 1024 | 32-bit extended logical destinations |
| out_valid | output | 1 | Delivery result valid |
| out_mask | output | 32 | One bit per agent receiving the delivery |
| out_kind | output | 3 | Delivery kind |
| out_vector | output | 8 | Vector for kind 1, else 0 |

## Verification
The block keeps no state between messages other than the held output register. A wrong match, broadcast or shorthand decision therefore shows as a wrong bit pattern in `out_mask` in the very cycle `out_valid` rises, and it cannot leak into later messages. Agents are given IDs that deliberately collide on the low 8 bits across modes, overlapping flat and cluster members, and an absent agent whose IDs would otherwise match. This way a mixed-up mode selection or presence gating flips at least one specific bit. A stale capture enable shows as outputs moving while `out_valid` is low.

// File: rtl/irq_fanout_pkg.sv
package irq_fanout_pkg;

  typedef enum logic [2:0] {
    KIND_NONE   = 3'd0,
    KIND_VECTOR = 3'd1,
    KIND_SMI    = 3'd2,
    KIND_NMI    = 3'd3,
    KIND_INIT   = 3'd4,
    KIND_ARBID  = 3'd5
  } dlv_kind_e;

  localparam logic [2:0] DLV_FIXED  = 3'b000;
  localparam logic [2:0] DLV_LOWEST = 3'b001;
  localparam logic [2:0] DLV_SMI    = 3'b010;
  localparam logic [2:0] DLV_NMI    = 3'b100;
  localparam logic [2:0] DLV_INIT   = 3'b101;

  localparam logic [1:0] SH_NONE   = 2'd0;
  localparam logic [1:0] SH_SELF   = 2'd1;
  localparam logic [1:0] SH_ALL    = 2'd2;
  localparam logic [1:0] SH_OTHERS = 2'd3;

endpackage

// File: rtl/irq_agent_match.sv
module irq_agent_match #(
  parameter int XW = 32,
  parameter int LW = 8
) (
  input  logic [XW-1:0] dest,
  input  logic          logical,
  input  logic          present,
  input  logic          x2,
  input  logic          cluster,
  input  logic [LW-1:0] id,
  input  logic [XW-1:0] xid,
  input  logic [LW-1:0] ldest,
  input  logic [XW-1:0] xldest,
  output logic          hit
);

  localparam int HX = XW / 2;
  localparam int NB = LW / 2;

  logic          all_ones;
  logic          legacy_bcast;
  logic [LW-1:0] dl;
  logic          phys_leg, phys_x2;
  logic          log_flat, log_clu, log_x2;
  logic          clu_sel;

  always_comb begin
    dl           = dest[LW-1:0];
    all_ones     = &dest;
    legacy_bcast = (dest == {{(XW-LW){1'b0}}, {LW{1'b1}}});
    phys_leg     = (dl == id) || legacy_bcast;
    phys_x2      = (dest == xid);
    log_flat     = |(dl & ldest);
    clu_sel      = (dl[LW-1:NB] == {NB{1'b1}}) || (dl[LW-1:NB] == ldest[LW-1:NB]);
    log_clu      = clu_sel && |(dl[NB-1:0] & ldest[NB-1:0]);
    log_x2       = (dest[XW-1:HX] == xldest[XW-1:HX]) && |(dest[HX-1:0] & xldest[HX-1:0]);

    if (!present) begin
      hit = 1'b0;
    end else if (!logical) begin
      hit = all_ones || (x2 ? phys_x2 : phys_leg);
    end else if (x2) begin
      hit = all_ones || log_x2;
    end else begin
      hit = cluster ? log_clu : log_flat;
    end
  end

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int N = 32
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);

  logic [N:0] seen;

  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign grant[g]  = req[g] && !seen[g];
    assign seen[g+1] = seen[g] || req[g];
  end

endmodule

// File: rtl/irq_dest_fanout.sv
module irq_dest_fanout
  import irq_fanout_pkg::*;
#(
  parameter int N  = 32,
  parameter int XW = 32,
  parameter int LW = 8,
  parameter int VW = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            msg_valid,
  input  logic [XW-1:0]   msg_dest,
  input  logic            msg_logical,
  input  logic [2:0]      msg_dlv,
  input  logic            msg_level,
  input  logic            msg_trig,
  input  logic [1:0]      msg_short,
  input  logic [VW-1:0]   msg_vector,
  input  logic [IDX_W-1:0] msg_sender,
  input  logic [N-1:0]    agt_present,
  input  logic [N-1:0]    agt_x2,
  input  logic [N-1:0]    agt_cluster,
  input  logic [N*LW-1:0] agt_id,
  input  logic [N*XW-1:0] agt_xid,
  input  logic [N*LW-1:0] agt_ldest,
  input  logic [N*XW-1:0] agt_xldest,
  output logic            out_valid,
  output logic [N-1:0]    out_mask,
  output logic [2:0]      out_kind,
  output logic [VW-1:0]   out_vector
);

  logic [N-1:0]  match_v;
  logic [N-1:0]  sender_oh;
  logic [N-1:0]  sel_v;
  logic [N-1:0]  low_v;
  dlv_kind_e     kind_nxt;
  logic [N-1:0]  mask_nxt;
  logic [VW-1:0] vec_nxt;

  logic          valid_q;
  logic [N-1:0]  mask_q;
  dlv_kind_e     kind_q;
  logic [VW-1:0] vec_q;

  for (genvar a = 0; a < N; a++) begin : g_agent
    irq_agent_match #(.XW(XW), .LW(LW)) u_match (
      .dest    (msg_dest),
      .logical (msg_logical),
      .present (agt_present[a]),
      .x2      (agt_x2[a]),
      .cluster (agt_cluster[a]),
      .id      (agt_id[a*LW +: LW]),
      .xid     (agt_xid[a*XW +: XW]),
      .ldest   (agt_ldest[a*LW +: LW]),
      .xldest  (agt_xldest[a*XW +: XW]),
      .hit     (match_v[a])
    );
  end

  irq_lowest_pick #(.N(N)) u_pick (
    .req   (sel_v),
    .grant (low_v)
  );

  // Selection: shorthand overrides the destination match
  always_comb begin
    sender_oh = agt_present & (N'(1) << msg_sender);
    unique case (msg_short)
      SH_SELF:   sel_v = sender_oh;
      SH_ALL:    sel_v = agt_present;
      SH_OTHERS: sel_v = agt_present & ~(N'(1) << msg_sender);
      default:   sel_v = match_v;
    endcase
  end

  // Delivery kind and final mask
  always_comb begin
    unique case (msg_dlv)
      DLV_FIXED, DLV_LOWEST: kind_nxt = KIND_VECTOR;
      DLV_SMI:               kind_nxt = KIND_SMI;
      DLV_NMI:               kind_nxt = KIND_NMI;
      DLV_INIT:              kind_nxt = (!msg_level && msg_trig) ? KIND_ARBID : KIND_INIT;
      default:               kind_nxt = KIND_NONE;
    endcase

    if (kind_nxt == KIND_NONE) begin
      mask_nxt = '0;
    end else if (msg_dlv == DLV_LOWEST) begin
      mask_nxt = low_v;
    end else begin
      mask_nxt = sel_v;
    end

    vec_nxt = (kind_nxt == KIND_VECTOR) ? msg_vector : '0;
  end

  // Output register, captured only when a message arrives
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
      kind_q  <= KIND_NONE;
      vec_q   <= '0;
    end else begin
      valid_q <= msg_valid;
      if (msg_valid) begin
        mask_q <= mask_nxt;
        kind_q <= kind_nxt;
        vec_q  <= vec_nxt;
      end
    end
  end

  assign out_valid  = valid_q;
  assign out_mask   = mask_q;
  assign out_kind   = kind_q;
  assign out_vector = vec_q;

endmodule

// File: rtl/irq_fanout_chk.sv
module irq_fanout_chk
  import irq_fanout_pkg::*;
#(
  parameter int N = 32,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic [2:0]       msg_dlv,
  input logic [1:0]       msg_short,
  input logic [IDX_W-1:0] msg_sender,
  input logic [N-1:0]     agt_present,
  input logic             out_valid,
  input logic [N-1:0]     out_mask,
  input logic [2:0]       out_kind
);

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> out_valid);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |=> (!out_valid && $stable(out_mask) && $stable(out_kind)));

  p_absent_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_mask & ~$past(agt_present)) == '0));

  p_lowest_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(msg_dlv) == DLV_LOWEST) |-> $onehot0(out_mask));

  p_self_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(msg_short) == SH_SELF) |->
      ((out_mask & ~(N'(1) << $past(msg_sender))) == '0));

  p_others_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(msg_short) == SH_OTHERS) |->
      ((out_mask & (N'(1) << $past(msg_sender))) == '0));

  p_none_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_kind == 3'(KIND_NONE)) |-> (out_mask == '0));

endmodule

bind irq_dest_fanout irq_fanout_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .msg_valid   (msg_valid),
  .msg_dlv     (msg_dlv),
  .msg_short   (msg_short),
  .msg_sender  (msg_sender),
  .agt_present (agt_present),
  .out_valid   (out_valid),
  .out_mask    (out_mask),
  .out_kind    (out_kind)
);

// File: tb/sim_irq_dest_fanout.sv
`timescale 1ns/1ps
module sim_irq_dest_fanout;

  localparam int N = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            msg_valid;
  logic [31:0]     msg_dest;
  logic            msg_logical;
  logic [2:0]      msg_dlv;
  logic            msg_level;
  logic            msg_trig;
  logic [1:0]      msg_short;
  logic [7:0]      msg_vector;
  logic [4:0]      msg_sender;
  logic [N-1:0]    agt_present, agt_x2, agt_cluster;
  logic [N*8-1:0]  agt_id, agt_ldest;
  logic [N*32-1:0] agt_xid, agt_xldest;
  logic            out_valid;
  logic [N-1:0]    out_mask;
  logic [2:0]      out_kind;
  logic [7:0]      out_vector;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_dest_fanout u0 (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_dest(msg_dest),
    .msg_logical(msg_logical), .msg_dlv(msg_dlv), .msg_level(msg_level),
    .msg_trig(msg_trig), .msg_short(msg_short), .msg_vector(msg_vector),
    .msg_sender(msg_sender), .agt_present(agt_present), .agt_x2(agt_x2),
    .agt_cluster(agt_cluster), .agt_id(agt_id), .agt_xid(agt_xid),
    .agt_ldest(agt_ldest), .agt_xldest(agt_xldest), .out_valid(out_valid),
    .out_mask(out_mask), .out_kind(out_kind), .out_vector(out_vector)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Agents 0..7 legacy flat, 8..15 legacy cluster, 16..23 legacy flat,
  // 24..30 extended, 31 absent (extended). Legacy ID = i+0x10.
  task automatic cfg_default();
    for (int i = 0; i < N; i++) begin
      agt_present[i] = (i != 31);
      agt_x2[i]      = (i >= 24);
      agt_cluster[i] = (i >= 8 && i < 16);
      agt_id[i*8 +: 8]    = 8'(i + 16);
      agt_xid[i*32 +: 32] = 32'h0001_0000 + 32'(i);
      if (i < 8)       agt_ldest[i*8 +: 8] = 8'(1 << i);
      else if (i < 16) agt_ldest[i*8 +: 8] = {4'((i-8)/4), 4'(1 << (i%4))};
      else if (i < 24) agt_ldest[i*8 +: 8] = 8'(1 << (i-16));
      else             agt_ldest[i*8 +: 8] = 8'h00;
      agt_xldest[i*32 +: 32] = (i >= 24) ? {16'h0007, 16'(1 << (i-24))} : 32'hFFFF_FFFF;
    end
  endtask

  task automatic send(logic [31:0] dest, logic lg, logic [2:0] dlv,
                      logic lvl, logic trg, logic [1:0] sh,
                      logic [7:0] vec, logic [4:0] snd);
    @(negedge clk);
    msg_valid = 1'b1; msg_dest = dest; msg_logical = lg; msg_dlv = dlv;
    msg_level = lvl; msg_trig = trg; msg_short = sh; msg_vector = vec;
    msg_sender = snd;
    @(negedge clk);
    msg_valid = 1'b0;
    check("R1 valid", 32'(out_valid), 32'd1);
  endtask

  task automatic t_reset();
    check("R1 reset valid", 32'(out_valid), 32'd0);
    check("R1 reset mask", out_mask, 32'h0);
    check("R1 reset kind", 32'(out_kind), 32'd0);
  endtask

  task automatic t_physical();
    send(32'h0000_0113, 1'b0, 3'b000, 1'b0, 1'b0, 2'd0, 8'h41, 5'd0);
    check("R2 legacy low8", out_mask, 32'h0000_0008);
    check("R9 vector kind", 32'(out_kind), 32'd1);
    check("R9 vector value", 32'(out_vector), 32'h41);
    send(32'h0001_001A, 1'b0, 3'b000, 1'b0, 1'b0, 2'd0, 8'h42, 5'd0);
    check("R2 extended id", out_mask, 32'h0400_0400);
  endtask

  task automatic t_phys_bcast();
    send(32'hFFFF_FFFF, 1'b0, 3'b000, 1'b0, 1'b0, 2'd0, 8'h43, 5'd0);
    check("R3 all ones", out_mask, 32'h7FFF_FFFF);
    send(32'h0000_00FF, 1'b0, 3'b000, 1'b0, 1'b0, 2'd0, 8'h44, 5'd0);
    check("R3 legacy bcast", out_mask, 32'h00FF_FFFF);
    send(32'h0000_01FF, 1'b0, 3'b000, 1'b0, 1'b0, 2'd0, 8'h45, 5'd0);
    check("R3 not exact ff", out_mask, 32'h0000_0000);
  endtask

  task automatic t_flat_cluster();
    send(32'h0000_0005, 1'b1, 3'b000, 1'b0, 1'b0, 2'd0, 8'h50, 5'd0);
    check("R4 flat", out_mask, 32'h0005_0505);
    send(32'h0000_0012, 1'b1, 3'b000, 1'b0, 1'b0, 2'd0, 8'h51, 5'd0);
    check("R5 cluster 1", out_mask, 32'h0012_2012);
    send(32'h0000_00F8, 1'b1, 3'b000, 1'b0, 1'b0, 2'd0, 8'h52, 5'd0);
    check("R5 cluster F", out_mask, 32'h00F8_88F8);
  endtask

  task automatic t_ext_logical();
    send(32'h0007_0005, 1'b1, 3'b000, 1'b0, 1'b0, 2'd0, 8'h60, 5'd0);
    check("R6 ext match", out_mask, 32'h0505_0505);
    send(32'h0006_0005, 1'b1, 3'b000, 1'b0, 1'b0, 2'd0, 8'h61, 5'd0);
    check("R6 ext cluster miss", out_mask, 32'h0005_0505);
    send(32'hFFFF_FFFF, 1'b1, 3'b000, 1'b0, 1'b0, 2'd0, 8'h62, 5'd0);
    check("R6 logical bcast", out_mask, 32'h7FFF_FFFF);
  endtask

  task automatic t_shorthand();
    send(32'h0000_0113, 1'b0, 3'b000, 1'b0, 1'b0, 2'd1, 8'h70, 5'd5);
    check("R7 self", out_mask, 32'h0000_0020);
    send(32'h0000_0113, 1'b0, 3'b000, 1'b0, 1'b0, 2'd2, 8'h71, 5'd5);
    check("R7 all", out_mask, 32'h7FFF_FFFF);
    send(32'h0000_0113, 1'b1, 3'b000, 1'b0, 1'b0, 2'd3, 8'h72, 5'd5);
    check("R7 others", out_mask, 32'h7FFF_FFDF);
    send(32'h0000_0000, 1'b0, 3'b000, 1'b0, 1'b0, 2'd1, 8'h73, 5'd31);
    check("R10 absent self", out_mask, 32'h0000_0000);
  endtask

  task automatic t_lowest();
    send(32'h0000_0012, 1'b1, 3'b001, 1'b0, 1'b0, 2'd0, 8'h80, 5'd0);
    check("R8 lowest", out_mask, 32'h0000_0002);
    check("R8 kind", 32'(out_kind), 32'd1);
    send(32'h0000_0000, 1'b0, 3'b001, 1'b0, 1'b0, 2'd3, 8'h81, 5'd0);
    check("R8 lowest others", out_mask, 32'h0000_0002);
    send(32'h0000_0077, 1'b0, 3'b001, 1'b0, 1'b0, 2'd0, 8'h82, 5'd0);
    check("R8 lowest empty", out_mask, 32'h0000_0000);
  endtask

  task automatic t_kinds();
    send(32'h0000_0013, 1'b0, 3'b010, 1'b0, 1'b0, 2'd0, 8'h90, 5'd0);
    check("R9 smi kind", 32'(out_kind), 32'd2);
    check("R9 smi mask", out_mask, 32'h0000_0008);
    check("R9 smi vector", 32'(out_vector), 32'h0);
    send(32'h0000_0013, 1'b0, 3'b100, 1'b0, 1'b0, 2'd0, 8'h91, 5'd0);
    check("R9 nmi kind", 32'(out_kind), 32'd3);
    send(32'h0000_0013, 1'b0, 3'b101, 1'b1, 1'b0, 2'd0, 8'h92, 5'd0);
    check("R9 init kind", 32'(out_kind), 32'd4);
    send(32'h0000_0000, 1'b0, 3'b101, 1'b0, 1'b1, 2'd2, 8'h93, 5'd0);
    check("R9 arbid kind", 32'(out_kind), 32'd5);
    check("R9 arbid mask", out_mask, 32'h7FFF_FFFF);
    send(32'h0000_0013, 1'b0, 3'b011, 1'b0, 1'b0, 2'd0, 8'h94, 5'd0);
    check("R9 none kind", 32'(out_kind), 32'd0);
    check("R9 none mask", out_mask, 32'h0);
  endtask

  task automatic t_absent();
    send(32'h0001_001F, 1'b0, 3'b000, 1'b0, 1'b0, 2'd0, 8'hA0, 5'd0);
    check("R10 absent ext id", out_mask, 32'h0000_8000);
    agt_present = '0;
    send(32'hFFFF_FFFF, 1'b0, 3'b000, 1'b0, 1'b0, 2'd2, 8'hA1, 5'd0);
    check("R10 none present", out_mask, 32'h0);
    cfg_default();
  endtask

  task automatic t_hold();
    send(32'h0000_0113, 1'b0, 3'b000, 1'b0, 1'b0, 2'd0, 8'hB0, 5'd0);
    msg_dest = 32'hFFFF_FFFF; msg_short = 2'd2; msg_dlv = 3'b010;
    @(negedge clk);
    check("R1 idle valid", 32'(out_valid), 32'd0);
    check("R1 hold mask", out_mask, 32'h0000_0008);
    check("R1 hold kind", 32'(out_kind), 32'd1);
    check("R1 hold vector", 32'(out_vector), 32'hB0);
  endtask

  initial begin
    rst_n = 1'b0; msg_valid = 1'b0; msg_dest = '0; msg_logical = 1'b0;
    msg_dlv = '0; msg_level = 1'b0; msg_trig = 1'b0; msg_short = '0;
    msg_vector = '0; msg_sender = '0;
    cfg_default();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_physical();
    t_phys_bcast();
    t_flat_cluster();
    t_ext_logical();
    t_shorthand();
    t_lowest();
    t_kinds();
    t_absent();
    t_hold();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule